// File: doc/BRIEF.md
# Sized-Word Data Port for a Serial Flash Host

This block sits between a processor's register bus and the serial shifter of a flash host controller. The processor writes words to be transmitted. Each word carries a byte count of 1 to 4, chosen by which of four write addresses is used. Both directions have a 63-word FIFO. The transmit side hands the valid bytes of each word to the shifter one byte per handshake, least-significant byte first, and never offers bytes the size does not cover.

Every byte sent produces one byte received. The receive side therefore rebuilds words of the same sizes, in the same order, as the transmit side emitted. A word of fewer than four bytes is returned in the upper byte lanes of the read value, with the lower lanes cleared. The processor pops received words by reading one address. A write to a full transmit FIFO is dropped, and a read from an empty receive FIFO returns zero. Each of these raises a one-cycle flag.

Top module: `flash_fifo_port`

## Requirements
- R1: A write to address 0x1C stores a 4-byte word. Writes to 0x80, 0x84 and 0x88 store words of 1, 2 and 3 bytes. A write to any other address changes nothing.
- R2: The bytes of a transmit word are offered in order from bits [7:0] upward, exactly as many as its size. `tx_last` is high on the final byte of each word. Bytes above the size are never offered.
- R3: While `tx_vld` is high and `tx_rdy` is low, `tx_vld`, `tx_data` and `tx_last` hold their values on the next cycle.
- R4: A received word of N bytes places its k-th received byte (k from 0) in byte lane 4-N+k, where lane 0 is bits [7:0]. Lanes below 4-N read as zero. Received word sizes follow the transmitted word sizes in order.
- R5: A read of address 0x20 pops the oldest received word. That word appears on `bus_rdata` in the cycle after the read and stays there until the next read.
- R6: A write to a valid transmit address while the transmit FIFO holds 63 words is discarded, and `tx_ovf` is high for the one cycle after it.
- R7: A read of 0x20 while the receive FIFO is empty gives zero on `bus_rdata`, and `rx_unf` is high for the one cycle after it.
- R8: After reset, `tx_vld`, `tx_ovf` and `rx_unf` are low and `bus_rdata` is zero.
- R9: Each FIFO accepts 63 words before it reports full. All 63 words are later delivered intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| tx_ovf | output | 1 | Pulse: a transmit write was dropped |
| rx_unf | output | 1 | Pulse: a read found the receive FIFO empty |
| tx_vld | output | 1 | A transmit byte is offered |
| tx_data | output | 8 | Offered transmit byte |
| tx_last | output | 1 | Offered byte ends its word |
| tx_rdy | input | 1 | Shifter takes the offered byte |
| rx_vld | input | 1 | A received byte is presented |
| rx_data | input | 8 | Received byte |

## Verification
The bench runs a loopback: each byte the shifter takes comes back on the receive side one cycle later, with a fixed pattern XORed in. This lets transmitted and received words be predicted from the writes alone. Random traffic uses random upper bytes in every partial write and switches word size only after the transmit FIFO empties. The upper bytes separate correct byte masking from leakage, and the size switches separate correct lane placement for 1, 2, 3 and 4 bytes. Random stalls on `tx_rdy` expose a drain that advances without a handshake. Directed runs cover the following:
- reading an empty receive FIFO;
- writes to an address outside the map;
- filling the transmit FIFO to 63 words with the shifter stalled, followed by a 64th write, which must be the only one lost.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int WORD_W = 32;
  localparam int LANE_W = 8;

  // Size tag: number of valid bytes modulo 4 (0 stands for a full word)
  typedef enum logic [1:0] {
    SZ_FULL  = 2'd0,
    SZ_ONE   = 2'd1,
    SZ_TWO   = 2'd2,
    SZ_THREE = 2'd3
  } size_tag_e;

  typedef struct packed {
    size_tag_e           tag;
    logic [WORD_W-1:0]   data;
  } tx_entry_t;

  localparam int ENTRY_W = $bits(tx_entry_t);

  function automatic logic [2:0] tag_bytes(input size_tag_e t);
    logic [2:0] n;
    if (t == SZ_FULL) n = 3'd4;
    else              n = {1'b0, logic'(t[1]), logic'(t[0])};
    return n;
  endfunction
endpackage

// File: rtl/fp_fifo.sv
module fp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt_q == FULL_CNT);
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp_q];

  always_comb begin
    wp_n  = do_push ? bump(wp_q) : wp_q;
    rp_n  = do_pop  ? bump(rp_q) : rp_q;
    cnt_n = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end
endmodule

// File: rtl/fp_tx_drain.sv
module fp_tx_drain
  import fp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  tx_entry_t  head,
  input  logic       head_ok,
  input  logic       infl_full,
  input  logic       tx_rdy,
  output logic       tx_vld,
  output logic [7:0] tx_data,
  output logic       tx_last,
  output logic       pop,
  output logic       start
);
  logic [1:0]        idx_q, idx_n;
  logic [2:0]        nbytes;
  logic              opening, fire;
  logic [WORD_W-1:0] shifted;

  assign nbytes  = tag_bytes(head.tag);
  assign opening = (idx_q == 2'd0);
  assign shifted = head.data >> {idx_q, 3'b000};
  assign tx_data = shifted[LANE_W-1:0];
  assign tx_vld  = head_ok && (!opening || !infl_full);
  assign tx_last = (({1'b0, idx_q}) + 3'd1) == nbytes;
  assign fire    = tx_vld && tx_rdy;
  assign pop     = fire && tx_last;
  assign start   = fire && opening;

  always_comb begin
    idx_n = idx_q;
    if (fire) idx_n = tx_last ? 2'd0 : idx_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= 2'd0;
    else        idx_q <= idx_n;
  end
endmodule

// File: rtl/fp_rx_pack.sv
module fp_rx_pack
  import fp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_vld,
  input  logic [7:0]        rx_data,
  input  size_tag_e         want_tag,
  input  logic              infl_ok,
  output logic              word_push,
  output logic [WORD_W-1:0] word,
  output logic              infl_pop
);
  logic [2:0]        cnt_q, cnt_n;
  logic [WORD_W-1:0] sh_q, sh_n, shifted;
  logic              take, done;

  // Each new byte enters the top lane; earlier bytes move down one lane
  assign shifted   = {rx_data, sh_q[WORD_W-1:LANE_W]};
  assign take      = rx_vld && infl_ok;
  assign done      = take && ((cnt_q + 3'd1) == tag_bytes(want_tag));
  assign word      = shifted;
  assign word_push = done;
  assign infl_pop  = done;

  always_comb begin
    cnt_n = cnt_q;
    sh_n  = sh_q;
    if (take) begin
      cnt_n = done ? 3'd0 : cnt_q + 3'd1;
      sh_n  = done ? '0 : shifted;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 3'd0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
    end
  end
endmodule

// File: rtl/flash_fifo_port.sv
module flash_fifo_port
  import fp_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                FIFO_DEPTH  = 63,
  parameter int                INFL_DEPTH  = 4,
  parameter logic [ADDR_W-1:0] A_TX_WORD   = 8'h1C,
  parameter logic [ADDR_W-1:0] A_TX_ONE    = 8'h80,
  parameter logic [ADDR_W-1:0] A_TX_TWO    = 8'h84,
  parameter logic [ADDR_W-1:0] A_TX_THREE  = 8'h88,
  parameter logic [ADDR_W-1:0] A_RX        = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_ovf,
  output logic              rx_unf,
  output logic              tx_vld,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_rdy,
  input  logic              rx_vld,
  input  logic [7:0]        rx_data
);
  // Write decode
  logic      wr_hit;
  size_tag_e wr_tag;

  always_comb begin
    wr_hit = 1'b0;
    wr_tag = SZ_FULL;
    if (bus_wr) begin
      case (bus_addr)
        A_TX_WORD:  begin wr_hit = 1'b1; wr_tag = SZ_FULL;  end
        A_TX_ONE:   begin wr_hit = 1'b1; wr_tag = SZ_ONE;   end
        A_TX_TWO:   begin wr_hit = 1'b1; wr_tag = SZ_TWO;   end
        A_TX_THREE: begin wr_hit = 1'b1; wr_tag = SZ_THREE; end
        default:    ;
      endcase
    end
  end

  // Transmit FIFO
  tx_entry_t tx_in, tx_head;
  logic      txf_empty, txf_full, txf_pop;
  logic [ENTRY_W-1:0] tx_head_raw;

  assign tx_in   = '{tag: wr_tag, data: bus_wdata};
  assign tx_head = tx_entry_t'(tx_head_raw);

  fp_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n),
    .push(wr_hit), .wdata(tx_in),
    .pop(txf_pop), .rdata(tx_head_raw),
    .empty(txf_empty), .full(txf_full)
  );

  // Sizes of words on the wire, awaiting their returning bytes
  logic       infl_push, infl_pop, infl_empty, infl_full;
  logic [1:0] infl_head;

  fp_fifo #(.W(2), .DEPTH(INFL_DEPTH)) u_infl (
    .clk(clk), .rst_n(rst_n),
    .push(infl_push), .wdata(tx_head.tag),
    .pop(infl_pop), .rdata(infl_head),
    .empty(infl_empty), .full(infl_full)
  );

  fp_tx_drain u_drain (
    .clk(clk), .rst_n(rst_n),
    .head(tx_head), .head_ok(!txf_empty), .infl_full(infl_full),
    .tx_rdy(tx_rdy), .tx_vld(tx_vld), .tx_data(tx_data),
    .tx_last(tx_last), .pop(txf_pop), .start(infl_push)
  );

  // Receive packing and FIFO
  logic              rxw_push;
  logic [WORD_W-1:0] rxw_data, rx_head;
  logic              rxf_empty, rxf_full, rxf_pop;

  fp_rx_pack u_pack (
    .clk(clk), .rst_n(rst_n),
    .rx_vld(rx_vld), .rx_data(rx_data),
    .want_tag(size_tag_e'(infl_head)), .infl_ok(!infl_empty),
    .word_push(rxw_push), .word(rxw_data), .infl_pop(infl_pop)
  );

  fp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n),
    .push(rxw_push), .wdata(rxw_data),
    .pop(rxf_pop), .rdata(rx_head),
    .empty(rxf_empty), .full(rxf_full)
  );

  // Read path and flags
  logic        rd_hit;
  logic [31:0] rdata_q, rdata_n;
  logic        ovf_q, ovf_n, unf_q, unf_n;

  assign rd_hit  = bus_rd && (bus_addr == A_RX);
  assign rxf_pop = rd_hit && !rxf_empty;

  always_comb begin
    rdata_n = rdata_q;
    if (rd_hit) rdata_n = rxf_empty ? '0 : rx_head;
    unf_n = rd_hit && rxf_empty;
    ovf_n = wr_hit && txf_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_n;
      ovf_q   <= ovf_n;
      unf_q   <= unf_n;
    end
  end

  assign bus_rdata = rdata_q;
  assign tx_ovf    = ovf_q;
  assign rx_unf    = unf_q;
endmodule

// File: rtl/fp_port_checker.sv
module fp_port_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [31:0] bus_rdata,
  input logic        tx_ovf,
  input logic        rx_unf,
  input logic        tx_vld,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic        tx_rdy
);
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld && !tx_rdy |=> tx_vld);  // R3
  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld && !tx_rdy |=> $stable(tx_data) && $stable(tx_last));  // R3
  AST_OVF_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |-> $past(bus_wr));  // R6
  AST_UNF_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rx_unf |-> $past(bus_rd) && bus_rdata == 32'd0);  // R7
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata));  // R5
endmodule

bind flash_fifo_port fp_port_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .tx_ovf(tx_ovf), .rx_unf(rx_unf),
  .tx_vld(tx_vld), .tx_data(tx_data), .tx_last(tx_last), .tx_rdy(tx_rdy)
);

// File: tb/flash_fifo_port_test.sv
module flash_fifo_port_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] LOOP_XOR = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        tx_ovf, rx_unf, tx_vld, tx_last, tx_rdy, rx_vld;
  logic [7:0]  tx_data, rx_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_fifo_port uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_ovf(tx_ovf), .rx_unf(rx_unf), .tx_vld(tx_vld), .tx_data(tx_data),
    .tx_last(tx_last), .tx_rdy(tx_rdy), .rx_vld(rx_vld), .rx_data(rx_data)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model state
  logic [7:0]  byte_q[$];
  bit          last_q[$];
  int          size_q[$];
  logic [31:0] rxw_q[$];
  logic [7:0]  acc[4];
  int          acc_n = 0;
  int          pending_words = 0;
  bit          loop_pend = 0, commit_pend = 0, rd_pend = 0, held_pend = 0;
  logic [7:0]  loop_byte, held_byte;
  logic [31:0] commit_word, rd_exp;
  bit          exp_ovf = 0, exp_unf = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R1: address to byte count map
  function automatic int addr_bytes(input logic [7:0] a);
    case (a)
      8'h1C:   return 4;
      8'h80:   return 1;
      8'h84:   return 2;
      8'h88:   return 3;
      default: return 0;
    endcase
  endfunction

  // R4: byte k of an N-byte word sits in lane 4-N+k
  function automatic logic [31:0] pack_word(input int n);
    logic [31:0] w = '0;
    for (int k = 0; k < n; k++) w[8*(4-n+k) +: 8] = acc[k];
    return w;
  endfunction

  task automatic step(input bit wr, input logic [7:0] a, input logic [31:0] d,
                      input bit rd, input bit rdy, input bit drop);
    int n;
    bit l;
    @(negedge clk);
    chk(tx_ovf == exp_ovf, "R6 ovf flag", 32'(tx_ovf), 32'(exp_ovf));
    chk(rx_unf == exp_unf, "R7 unf flag", 32'(rx_unf), 32'(exp_unf));
    if (rd_pend) chk(bus_rdata == rd_exp, "R4/R5 read word", bus_rdata, rd_exp);
    rd_pend = 0;
    if (held_pend)
      chk(tx_vld && tx_data == held_byte, "R3 held byte", {23'd0, tx_vld, tx_data}, {24'd1, held_byte});
    if (commit_pend) rxw_q.push_back(commit_word);
    commit_pend = 0;
    // loopback of the byte taken at the last edge
    if (loop_pend) begin
      rx_vld  = 1'b1;
      rx_data = loop_byte ^ LOOP_XOR;
      acc[acc_n] = rx_data;
      acc_n++;
      if (acc_n == size_q[0]) begin
        commit_word = pack_word(acc_n);
        commit_pend = 1;
        void'(size_q.pop_front());
        acc_n = 0;
      end
      loop_pend = 0;
    end else begin
      rx_vld = 1'b0;
    end
    // drain side
    tx_rdy = rdy;
    if (tx_vld && rdy) begin
      if (byte_q.size() == 0) begin
        chk(0, "R2 unexpected byte", {24'd0, tx_data}, 32'd0);
      end else begin
        chk(tx_data == byte_q[0], "R2 tx byte", {24'd0, tx_data}, {24'd0, byte_q[0]});
        l = last_q.pop_front();
        void'(byte_q.pop_front());
        chk(tx_last == l, "R2 tx_last", 32'(tx_last), 32'(l));
        if (l) pending_words--;
      end
      loop_pend = 1;
      loop_byte = tx_data;
    end
    held_pend = tx_vld && !rdy;
    held_byte = tx_data;
    // bus side
    exp_ovf = 0;
    exp_unf = 0;
    bus_wr = wr;
    bus_rd = rd;
    bus_addr = rd ? 8'h20 : a;
    bus_wdata = d;
    if (wr) begin
      n = addr_bytes(a);
      if (n > 0) begin
        if (drop) exp_ovf = 1;
        else begin
          for (int k = 0; k < n; k++) begin
            byte_q.push_back(d[8*k +: 8]);
            last_q.push_back(k == n-1);
          end
          size_q.push_back(n);
          pending_words++;
        end
      end
    end
    if (rd) begin
      rd_pend = 1;
      if (rxw_q.size() > 0) rd_exp = rxw_q.pop_front();
      else begin rd_exp = '0; exp_unf = 1; end
    end
  endtask

  task automatic drain_all();
    for (int i = 0; i < 3000; i++) begin
      if (byte_q.size() == 0 && size_q.size() == 0 && rxw_q.size() == 0 &&
          !loop_pend && !commit_pend && !rd_pend) break;
      step(0, 8'h00, 32'd0, rxw_q.size() > 0, 1, 0);
    end
    step(0, 8'h00, 32'd0, 0, 1, 0);
    chk(byte_q.size() == 0 && rxw_q.size() == 0, "R9 all delivered",
        32'(byte_q.size() + rxw_q.size()), 32'd0);
  endtask

  logic [7:0] size_addr[4] = '{8'h80, 8'h84, 8'h88, 8'h1C};

  initial begin
    logic [7:0] cur_a;
    bit switching;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    tx_rdy = 0; rx_vld = 0; rx_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    chk(!tx_vld && !tx_ovf && !rx_unf, "R8 reset flags", {29'd0, tx_vld, tx_ovf, rx_unf}, 32'd0);
    chk(bus_rdata == 32'd0, "R8 reset rdata", bus_rdata, 32'd0);

    // R7: read of an empty receive FIFO
    step(0, 8'h00, 32'd0, 1, 1, 0);
    step(0, 8'h00, 32'd0, 0, 1, 0);

    // R1: writes outside the map change nothing; then one word of each size
    step(1, 8'h40, 32'hDEADBEEF, 0, 1, 0);
    step(1, 8'h20, 32'hCAFEF00D, 0, 1, 0);
    step(1, 8'h80, 32'hAABBCC11, 0, 1, 0);
    drain_all();
    step(1, 8'h84, 32'hAABB2211, 0, 1, 0);
    drain_all();
    step(1, 8'h88, 32'hAA332211, 0, 1, 0);
    drain_all();
    step(1, 8'h1C, 32'h44332211, 0, 1, 0);
    drain_all();

    // Random traffic; size changes only once the transmit side is empty
    cur_a = 8'h1C;
    switching = 0;
    for (int i = 0; i < 6000; i++) begin
      bit wr, rd, rdy;
      logic [7:0] a;
      if (!switching && ($urandom % 40) == 0) switching = 1;
      if (switching && pending_words == 0) begin
        cur_a = size_addr[$urandom % 4];
        switching = 0;
      end
      a = (($urandom % 25) == 0) ? 8'h44 : cur_a;
      wr = !switching && (size_q.size() + rxw_q.size() < 50) && ($urandom % 3 != 0);
      rd = !wr && (($urandom % 2) == 0);
      rdy = ($urandom % 4) != 0;
      step(wr, a, $urandom, rd, rdy, 0);
    end
    drain_all();

    // R6/R9: fill the transmit FIFO with the shifter stalled
    for (int i = 0; i < 63; i++) step(1, 8'h1C, 32'h01010101 * (i + 1), 0, 0, 0);
    step(1, 8'h1C, 32'hBAD0BAD0, 0, 0, 1);
    step(0, 8'h00, 32'd0, 0, 0, 0);
    chk(tx_vld == 1'b1, "R9 full FIFO offers data", 32'(tx_vld), 32'd1);
    drain_all();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule